// File: doc/BRIEF.md
# VFD Grid Scanner with Selectable Duty

This block produces the time-multiplexed grid scan of a vacuum fluorescent display. A frame holds a set number of grid slots, chosen by a 2-bit duty input. Each slot lasts a fixed number of clocks, and one grid is lit during each slot. The block reports the index of the grid currently being scanned, so that the anode data for that slot can be fetched from display memory.

Grids 0 to 23 (numbered from zero) drive on-chip outputs directly. In the 40-grid setting, grids 24 to 39 are driven by an external shift-register grid driver through four lines: serial data, shift clock, latch enable and an active-low clear. While the current slot runs, the block shifts in the pattern for the next slot. It pulses the latch at the next slot boundary. It holds the clear line low whenever the external grids must be dark.

Top module: `vfd_grid_scan`

## Requirements
- R1: The duty code sets the grids per frame as 00 = 16, 01 = 20, 10 = 24 and 11 = 40. `gridIdx` steps 0, 1, ..., N-1 and then wraps to 0.
- R2: Each grid slot lasts exactly `SLOT_CYCLES` clocks, and `gridIdx` holds its value through the slot. A frame of N grids therefore lasts N*`SLOT_CYCLES` clocks.
- R3: For a grid g below 24, `gridOut` has only bit g set during the first `SLOT_CYCLES`-`BLANK_CYCLES` clocks of its slot.
- R4: In the last `BLANK_CYCLES` clocks of every slot, `gridOut` is all zero. It is also all zero for the whole slot of any grid numbered 24 or above.
- R5: The duty code is sampled only on the last clock of a frame. A change made mid-frame leaves the current frame's length unchanged and takes effect with the next frame.
- R6: While `rst_n` is low, `gridOut`, `gridIdx`, `extData`, `extClk`, `extLatch` and `extClearN` are all zero. The duty code is also sampled on each reset clock.
- R7: In 40-grid mode, the serial lines are active during slot phases 0 to 31. `extClk` is high on the odd phases, and `extData` carries a 16-bit pattern for the next slot's grid, bit 15 first. Bit j set means grid 24+j. On all other phases, and in other modes, both lines are low.
- R8: `extLatch` is high for exactly one clock, at phase 0 of each slot that follows a slot run in 40-grid mode.
- R9: `extClearN` stays low from reset until the first `extLatch` pulse. After that, it is high in 40-grid mode outside the blanking clocks, and low in every other mode.
- R10: An external 16-stage shift register clocked by `extClk`, latched by `extLatch` and gated by `extClearN` shows, mid-slot, only grid g lit when g is 24 or above in 40-grid mode, and nothing otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dutySel | input | 2 | Duty code: 00 = 16, 01 = 20, 10 = 24, 11 = 40 grids |
| gridOut | output | 24 | On-chip grid drive, one-hot or zero |
| gridIdx | output | 6 | Index of the grid in the current slot |
| extData | output | 1 | Serial data to the external grid driver |
| extClk | output | 1 | Shift clock to the external grid driver |
| extLatch | output | 1 | Latch enable to the external grid driver |
| extClearN | output | 1 | Active-low clear to the external grid driver |

## Verification
The bench targets three corner cases:
- It changes the duty code in the middle of a 16-grid frame. A design that samples the code at once would wrap at the wrong grid.
- It walks a 40-grid frame into a 16-grid frame. The external latch must be reloaded with an all-zero pattern at that boundary, or grid 39 would stay lit on the external driver.
- It applies reset in the middle of a 40-grid scan, then checks that the clear line stays low through the first slot. A design that keeps its armed flag across reset would light stale external data.

A behavioural model of the external shift register catches shift-order and bit-position errors, which show up as the wrong external grid lit mid-slot.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

  localparam int ONCHIP_GRIDS = 24;
  localparam int MAX_GRIDS    = 40;
  localparam int EXT_GRIDS    = MAX_GRIDS - ONCHIP_GRIDS;
  localparam int IDX_W        = $clog2(MAX_GRIDS);

  typedef enum logic [1:0] {
    DUTY_16 = 2'b00,
    DUTY_20 = 2'b01,
    DUTY_24 = 2'b10,
    DUTY_40 = 2'b11
  } duty_e;

  // strobes from the sequencer to the output stage
  typedef struct packed {
    logic lit;    // slot is in its lit part
    logic latch;  // latch pulse for the external driver
    logic sClk;   // serial shift clock level
    logic sData;  // serial data level
    logic extOn;  // external grids may be enabled
  } scan_strobe_t;

  function automatic logic [IDX_W-1:0] gridCount(duty_e d);
    case (d)
      DUTY_16: gridCount = IDX_W'(16);
      DUTY_20: gridCount = IDX_W'(20);
      DUTY_24: gridCount = IDX_W'(24);
      default: gridCount = IDX_W'(MAX_GRIDS);
    endcase
  endfunction

endpackage

// File: rtl/vfd_scan_ctrl.sv
module vfd_scan_ctrl
  import vfd_scan_pkg::*;
#(
  parameter int SLOT_CYCLES  = 40,
  parameter int BLANK_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       dutySel,
  output scan_strobe_t     strobe,
  output logic [IDX_W-1:0] gridIdx
);

  localparam int PH_W         = $clog2(SLOT_CYCLES);
  localparam int LIT_CYCLES   = SLOT_CYCLES - BLANK_CYCLES;
  localparam int SHIFT_CYCLES = 2 * EXT_GRIDS;

  logic [PH_W-1:0]  phase;
  logic [IDX_W-1:0] grid;
  duty_e            code;
  logic             prev40;

  logic             slotEnd;
  logic             lastGrid;
  logic [IDX_W-1:0] nextGrid;
  logic [IDX_W-1:0] extPos;
  logic             inShift;

  assign slotEnd  = (phase == PH_W'(SLOT_CYCLES - 1));
  assign lastGrid = (grid == gridCount(code) - IDX_W'(1));
  assign nextGrid = lastGrid ? '0 : grid + IDX_W'(1);
  assign inShift  = (code == DUTY_40) && (phase < PH_W'(SHIFT_CYCLES));
  assign extPos   = IDX_W'(EXT_GRIDS - 1) - IDX_W'(phase >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      grid   <= '0;
      code   <= duty_e'(dutySel);
      prev40 <= 1'b0;
    end else if (slotEnd) begin
      phase  <= '0;
      prev40 <= (code == DUTY_40);
      if (lastGrid) begin
        grid <= '0;
        code <= duty_e'(dutySel);  // duty only changes at a frame edge
      end else begin
        grid <= grid + IDX_W'(1);
      end
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  always_comb begin
    strobe.lit   = (phase < PH_W'(LIT_CYCLES));
    strobe.latch = (phase == '0) && prev40;
    strobe.sClk  = inShift && phase[0];
    strobe.sData = inShift && (nextGrid >= IDX_W'(ONCHIP_GRIDS))
                   && ((nextGrid - IDX_W'(ONCHIP_GRIDS)) == extPos);
    strobe.extOn = (code == DUTY_40) && strobe.lit;
  end

  assign gridIdx = grid;

  // R1: index never reaches the selected grid count
  a_r1_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    grid < gridCount(code));

  // R5: duty register moves only when a new frame begins
  a_r5_duty_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (code != $past(code)) |-> (grid == '0 && phase == '0));

  // R2: index is steady inside a slot
  a_r2_idx_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != '0) |-> (grid == $past(grid)));

endmodule

// File: rtl/vfd_scan_dp.sv
module vfd_scan_dp
  import vfd_scan_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  scan_strobe_t            strobe,
  input  logic [IDX_W-1:0]        gridIdxIn,
  output logic [ONCHIP_GRIDS-1:0] gridOut,
  output logic [IDX_W-1:0]        gridIdx,
  output logic                    extData,
  output logic                    extClk,
  output logic                    extLatch,
  output logic                    extClearN
);

  logic [ONCHIP_GRIDS-1:0] litNext;
  logic                    armedQ;
  logic                    armedNext;

  for (genvar i = 0; i < ONCHIP_GRIDS; i++) begin : g_grid
    assign litNext[i] = strobe.lit && (gridIdxIn == IDX_W'(i));
  end

  assign armedNext = armedQ || strobe.latch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gridOut   <= '0;
      gridIdx   <= '0;
      extData   <= 1'b0;
      extClk    <= 1'b0;
      extLatch  <= 1'b0;
      extClearN <= 1'b0;
      armedQ    <= 1'b0;
    end else begin
      gridOut   <= litNext;
      gridIdx   <= gridIdxIn;
      extData   <= strobe.sData;
      extClk    <= strobe.sClk;
      extLatch  <= strobe.latch;
      extClearN <= armedNext && strobe.extOn;
      armedQ    <= armedNext;
    end
  end

  // R3: never more than one on-chip grid
  a_r3_single_grid: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gridOut));

  // R4: on-chip grids dark for external slots
  a_r4_ext_slot_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (gridOut != '0) |-> (gridIdx < IDX_W'(ONCHIP_GRIDS)));

  // R8: latch enable is a single-clock pulse
  a_r8_latch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    extLatch |=> !extLatch);

  // R7: no shift edge coincides with the latch pulse
  a_r7_clk_clear_of_latch: assert property (@(posedge clk) disable iff (!rst_n)
    extLatch |-> !extClk);

  // R9: clear only releases once a pattern has been latched
  a_r9_clear_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(extClearN) |-> armedQ);

endmodule

// File: rtl/vfd_grid_scan.sv
module vfd_grid_scan
  import vfd_scan_pkg::*;
#(
  parameter int SLOT_CYCLES  = 40,
  parameter int BLANK_CYCLES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              dutySel,
  output logic [ONCHIP_GRIDS-1:0] gridOut,
  output logic [IDX_W-1:0]        gridIdx,
  output logic                    extData,
  output logic                    extClk,
  output logic                    extLatch,
  output logic                    extClearN
);

  scan_strobe_t     strobe;
  logic [IDX_W-1:0] ctrlIdx;

  vfd_scan_ctrl #(
    .SLOT_CYCLES (SLOT_CYCLES),
    .BLANK_CYCLES(BLANK_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .dutySel(dutySel),
    .strobe (strobe),
    .gridIdx(ctrlIdx)
  );

  vfd_scan_dp u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .gridIdxIn(ctrlIdx),
    .gridOut  (gridOut),
    .gridIdx  (gridIdx),
    .extData  (extData),
    .extClk   (extClk),
    .extLatch (extLatch),
    .extClearN(extClearN)
  );

endmodule

// File: tb/sim_vfd_grid_scan.sv
module sim_vfd_grid_scan;

  localparam int PERIOD = 10;
  localparam int S      = 40;
  localparam int B      = 4;
  localparam int ON     = 24;
  localparam int EXT    = 16;

  // {duty code, expected grids per frame}
  localparam logic [7:0] VEC [5] = '{
    {2'd0, 6'd16}, {2'd1, 6'd20}, {2'd2, 6'd24}, {2'd3, 6'd40}, {2'd0, 6'd16}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  dutySel = 2'd0;
  logic [23:0] gridOut;
  logic [5:0]  gridIdx;
  logic        extData, extClk, extLatch, extClearN;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  vfd_grid_scan #(.SLOT_CYCLES(S), .BLANK_CYCLES(B)) u0 (
    .clk(clk), .rst_n(rst_n), .dutySel(dutySel),
    .gridOut(gridOut), .gridIdx(gridIdx),
    .extData(extData), .extClk(extClk), .extLatch(extLatch), .extClearN(extClearN)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int gridsFor(logic [1:0] s);
    case (s)
      2'd0: return 16;
      2'd1: return 20;
      2'd2: return 24;
      default: return 40;
    endcase
  endfunction

  // external shift-register driver model
  logic [15:0] sr = '0;
  logic [15:0] lat = '0;
  always @(posedge extClk) sr <= {sr[14:0], extData};
  always @(posedge extLatch) lat <= sr;

  // input history seen by the design at each edge
  logic       rstHist;
  logic [1:0] selHist, selPrev;
  always @(posedge clk) begin
    rstHist <= rst_n;
    selHist <= dutySel;
    selPrev <= selHist;
  end

  // cycle model of the requirements
  int mPh, mG;
  logic [1:0] mCode;
  bit mFirst = 1, mPrev40 = 0, mArmed = 0;

  always @(negedge clk) begin
    if (!done && rstHist === 1'b0) begin
      mFirst = 1; mPrev40 = 0; mArmed = 0;
      check({gridOut, gridIdx, extData, extClk, extLatch, extClearN} == '0,
            "R6", "outputs in reset", int'(gridOut), 0);
    end else if (!done && rstHist === 1'b1) begin
      int expGrid, gn, expVis, actVis;
      bit expLatch, expClear, inSh, expClk, expData;
      if (mFirst) begin
        mFirst = 0; mPh = 0; mG = 0; mCode = selPrev;
      end else if (mPh == S-1) begin
        mPh = 0;
        mPrev40 = (mCode == 2'd3);
        if (mG == gridsFor(mCode) - 1) begin mG = 0; mCode = selPrev; end
        else mG++;
      end else begin
        mPh++;
      end
      expGrid  = (mG < ON && mPh < S-B) ? (1 << mG) : 0;
      expLatch = (mPh == 0) && mPrev40;
      if (expLatch) mArmed = 1;
      expClear = mArmed && mCode == 2'd3 && mPh < S-B;
      gn       = (mG == gridsFor(mCode) - 1) ? 0 : mG + 1;
      inSh     = (mCode == 2'd3) && mPh < 2*EXT;
      expClk   = inSh && (mPh % 2 == 1);
      expData  = inSh && gn >= ON && (gn - ON) == (EXT - 1 - mPh/2);
      check(int'(gridIdx) == mG, "R2", "gridIdx", int'(gridIdx), mG);
      if (expGrid != 0) check(int'(gridOut) == expGrid, "R3", "gridOut", int'(gridOut), expGrid);
      else              check(gridOut == '0, "R4", "gridOut blank", int'(gridOut), 0);
      check(extLatch == expLatch, "R8", "extLatch", int'(extLatch), int'(expLatch));
      check(extClearN == expClear, "R9", "extClearN", int'(extClearN), int'(expClear));
      check({extClk, extData} == {expClk, expData}, "R7", "clk/data",
            int'({extClk, extData}), int'({expClk, expData}));
      if (mPh == S/2) begin
        actVis = extClearN ? int'(lat) : 0;
        expVis = (mCode == 2'd3 && mG >= ON) ? (1 << (mG - ON)) : 0;
        check(actVis == expVis, "R10", "external grids", actVis, expVis);
      end
    end
  end

  task automatic drive(logic r, logic [1:0] s);
    @(posedge clk); #2;
    rst_n = r; dutySel = s;
  endtask

  // waits for the next frame start; reports its cycle count and top index
  task automatic nextFrame(output int cyc, output int maxIdx);
    int prev;
    prev = int'(gridIdx); cyc = 0; maxIdx = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (gridIdx == 0 && prev != 0) break;
      if (int'(gridIdx) > maxIdx) maxIdx = int'(gridIdx);
      prev = int'(gridIdx);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    int cyc, mx;
    repeat (4) @(negedge clk);
    drive(1'b1, 2'd0);

    // duty table walk: R1 wrap point, R2 frame length
    for (int k = 0; k < 5; k++) begin
      drive(1'b1, VEC[k][7:6]);
      nextFrame(cyc, mx);
      nextFrame(cyc, mx);
      check(mx + 1 == int'(VEC[k][5:0]), "R1", "grids per frame", mx + 1, int'(VEC[k][5:0]));
      check(cyc == int'(VEC[k][5:0]) * S, "R2", "frame cycles", cyc, int'(VEC[k][5:0]) * S);
    end

    // R5: mid-frame change keeps the running 16-grid frame
    repeat (5*S) @(negedge clk);
    drive(1'b1, 2'd3);
    nextFrame(cyc, mx);
    check(mx == 15, "R5", "top index of changed frame", mx, 15);
    nextFrame(cyc, mx);
    check(mx == 39, "R5", "top index after change", mx, 39);

    // R6/R9: reset in 40-grid mode, clear held low until first latch
    repeat (30*S + 7) @(negedge clk);
    drive(1'b0, 2'd3);
    repeat (3) @(negedge clk);
    check(extClearN == 1'b0 && gridOut == '0, "R6", "reset mid-scan", int'(extClearN), 0);
    drive(1'b1, 2'd3);
    repeat (S/2) @(negedge clk);
    check(extClearN == 1'b0, "R9", "clear before first latch", int'(extClearN), 0);
    repeat (S) @(negedge clk);
    check(extClearN == 1'b1, "R9", "clear after first latch", int'(extClearN), 1);
    repeat (2*S) @(negedge clk);

    // R4/R10 handled by model over a full 40 frame into 16
    drive(1'b1, 2'd0);
    nextFrame(cyc, mx);
    nextFrame(cyc, mx);
    check(lat == '0, "R10", "external latch cleared after 40->16", int'(lat), 0);

    finishRun();
  end

endmodule